// File: doc/BRIEF.md
# SECDED SRAM Access Controller

This controller sits between a simple request port and an external synchronous SRAM. The SRAM stores each data word together with its check bits. A full-word write encodes the data with an extended Hamming code and stores the word with its check bits. A read fetches the stored word, recomputes the code, corrects any single-bit fault in the returned data and flags any double-bit fault. The data width is a parameter: 64 data bits take 8 check bits and 32 data bits take 7. Checking is always active and has no disable input.

A write whose byte enables are not all set becomes a read-modify-write. The controller reads the old word, checks it, merges the enabled bytes into it and writes the merged word back with fresh check bits. Any error found in the old word is reported. Every detected error raises a one-cycle event on the diagnostic outputs for an external monitor. The event carries the kind of error, whether a partial write found it, the word index and the raw data field as it was read.

The control path is a three-state machine. The states are `ST_IDLE`, `ST_RMW_CHECK` and `ST_RMW_WRITE`. Only `ST_IDLE` accepts requests. `ST_IDLE` moves to `ST_RMW_CHECK` when it accepts a partial write, and stays in `ST_IDLE` when it accepts a read or a full write or sees no request. `ST_RMW_CHECK` always moves to `ST_RMW_WRITE`, and `ST_RMW_WRITE` always returns to `ST_IDLE`.

Top module: `secded_sram_ctrl`

## Requirements
- R1: A write with all byte enables set drives the SRAM in its accept cycle. The stored word is `{h, p, data}`. Data bit i sits at the i-th code position, counting upward from 3, that is not a power of two. Hamming bit h[k] is the XOR of the data bits whose position has bit k set. p, stored at bit DW, makes the parity of the whole stored word even.
- R2: A read is accepted while `req_ready` is high. When the stored word is clean, `rsp_valid` is high exactly two cycles after the accept cycle, `rsp_data` equals the stored data, and no event output is raised.
- R3: A single flipped data bit is corrected in `rsp_data`. `single_err` is raised for one cycle in the response cycle, with `err_index` set to the word address and `err_data` set to the raw data field before correction. The stored word is not rewritten.
- R4: A single flipped bit among the check bits, including the overall parity bit at DW, is counted as a single error. `rsp_data` returns the stored data unchanged.
- R5: Two flipped bits raise `double_err` and never `single_err`. In that case `rsp_data` returns the raw data field.
- R6: A write with some byte enables cleared takes three cycles, and `req_ready` is low in the two cycles after the accept. The enabled bytes replace the old bytes, the other bytes keep their corrected old value, and the merged word is stored with fresh check bits.
- R7: An error found in the old word during a partial write raises `single_err` or `double_err` together with `is_partial_write`, two cycles after the accept.
- R8: A double error found during a partial write suppresses the write-back, so the stored word stays as it was.
- R9: After reset `rsp_valid`, `single_err`, `double_err` and `is_partial_write` are low and `req_ready` is high.
- R10: Reads accepted in consecutive cycles return their responses in consecutive cycles, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (state ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word index |
| req_be | input | DW/8 | Byte enables for writes |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Corrected read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | DW+CB | Word with check bits to store |
| mem_rdata | input | DW+CB | Stored word, one cycle after the read access |
| single_err | output | 1 | One-cycle event: corrected error |
| double_err | output | 1 | One-cycle event: uncorrectable error |
| is_partial_write | output | 1 | Event came from a read-modify-write |
| err_index | output | AW | Word index of the event |
| err_data | output | DW | Raw data field read, before correction |

## Verification
The bench models the SRAM and corrupts the stored words through a back door. It tries each access with zero, one and two flipped bits at random positions. A single flip in a data bit shows whether the faulty bit is located and corrected. A single flip in a check bit or in the parity bit shows that the data is left alone. Two flips show that a double error is detected and never miscorrected. Partial writes use random byte-enable masks over clean, single-fault and double-fault old words, which separates a correct merge and fresh encoding from a suppressed write. Back-to-back reads test response ordering.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RMW_CHECK,
        ST_RMW_WRITE
    } ctrl_state_t;

    // number of Hamming bits r with 2^r >= dw + r + 1
    function automatic int hamming_bits(input int dw);
        int r;
        r = 1;
        for (int k = 1; k < 12; k++) begin
            if ((1 << r) < dw + r + 1) r = k + 1;
        end
        return r;
    endfunction

    // code position of data bit idx: the idx-th non-power-of-two from 3 upward
    function automatic int data_pos(input int idx);
        int n;
        int res;
        n   = 0;
        res = 0;
        for (int p = 3; p < 256; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) res = p;
                n++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DW = 64,
    parameter int PB = 7
) (
    input  logic [DW-1:0] data,
    output logic [PB:0]   check
);

    logic [PB-1:0] pos_tab [DW];
    logic [PB-1:0] ham;

    for (genvar i = 0; i < DW; i++) begin : g_pos
        localparam int P = data_pos(i);
        assign pos_tab[i] = PB'(P);
    end

    always_comb begin
        ham = '0;
        for (int i = 0; i < DW; i++) begin
            if (data[i]) ham = ham ^ pos_tab[i];
        end
        check = {ham, ^{data, ham}};
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int DW = 64,
    parameter int PB = 7,
    localparam int SW = DW + PB + 1
) (
    input  logic [SW-1:0] word,
    output logic [DW-1:0] data_fix,
    output logic          single,
    output logic          double
);

    localparam logic [PB-1:0] NPOS_V = PB'(DW + PB);

    logic [PB-1:0] pos_tab [DW];
    logic [PB-1:0] ham;
    logic [PB-1:0] syn;
    logic          par;

    for (genvar i = 0; i < DW; i++) begin : g_pos
        localparam int P = data_pos(i);
        assign pos_tab[i] = PB'(P);
    end

    always_comb begin
        ham = '0;
        for (int i = 0; i < DW; i++) begin
            if (word[i]) ham = ham ^ pos_tab[i];
        end
        syn    = ham ^ word[SW-1:DW+1];
        par    = ^word;
        single = par && (syn <= NPOS_V);
        double = (!par && (syn != '0)) || (par && (syn > NPOS_V));
        for (int i = 0; i < DW; i++) begin
            data_fix[i] = word[i] ^ (par && (syn == pos_tab[i]));
        end
    end

    // R5
    dec_exclusive_chk: assert final (!(single && double));

endmodule

// File: rtl/secded_sram_ctrl.sv
module secded_sram_ctrl
    import secded_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PB   = hamming_bits(DW),
    localparam int CB   = PB + 1,
    localparam int SW   = DW + CB,
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [NB-1:0] req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [SW-1:0] mem_wdata,
    input  logic [SW-1:0] mem_rdata,
    output logic          single_err,
    output logic          double_err,
    output logic          is_partial_write,
    output logic [AW-1:0] err_index,
    output logic [DW-1:0] err_data
);

    ctrl_state_t   state, state_nx;
    logic          s1_rd;
    logic [AW-1:0] s1_addr;
    logic [DW-1:0] s1_wdata;
    logic [NB-1:0] s1_be;
    logic [DW-1:0] merged_q;
    logic          wr_ok_q;

    logic          acc, full_be, acc_rd, acc_part, in_check;
    logic [DW-1:0] enc_in;
    logic [CB-1:0] enc_check;
    logic [DW-1:0] dec_data;
    logic          dec_single, dec_double;
    logic [DW-1:0] merged;

    assign req_ready = (state == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign full_be   = &req_be;
    assign acc_rd    = acc && !req_write;
    assign acc_part  = acc && req_write && !full_be;
    assign in_check  = (state == ST_RMW_CHECK);
    assign enc_in    = (state == ST_RMW_WRITE) ? merged_q : req_wdata;

    secded_enc #(.DW(DW), .PB(PB)) i_enc (
        .data  (enc_in),
        .check (enc_check)
    );

    secded_dec #(.DW(DW), .PB(PB)) i_dec (
        .word     (mem_rdata),
        .data_fix (dec_data),
        .single   (dec_single),
        .double   (dec_double)
    );

    always_comb begin
        for (int j = 0; j < NB; j++) begin
            merged[j*8 +: 8] = s1_be[j] ? s1_wdata[j*8 +: 8] : dec_data[j*8 +: 8];
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (acc_part) state_nx = ST_RMW_CHECK;
            ST_RMW_CHECK: state_nx = ST_RMW_WRITE;
            ST_RMW_WRITE: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // SRAM drive
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = {enc_check, enc_in};
        unique case (state)
            ST_IDLE: begin
                mem_en = req_valid;
                mem_we = req_valid && req_write && full_be;
            end
            ST_RMW_CHECK: begin
                mem_en = 1'b0;
            end
            ST_RMW_WRITE: begin
                mem_en   = wr_ok_q;
                mem_we   = 1'b1;
                mem_addr = s1_addr;
            end
            default: mem_en = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_rd            <= 1'b0;
            s1_addr          <= '0;
            s1_wdata         <= '0;
            s1_be            <= '0;
            merged_q         <= '0;
            wr_ok_q          <= 1'b0;
            rsp_valid        <= 1'b0;
            rsp_data         <= '0;
            single_err       <= 1'b0;
            double_err       <= 1'b0;
            is_partial_write <= 1'b0;
            err_index        <= '0;
            err_data         <= '0;
        end else begin
            s1_rd <= acc_rd;
            if (acc) begin
                s1_addr  <= req_addr;
                s1_wdata <= req_wdata;
                s1_be    <= req_be;
            end
            rsp_valid <= s1_rd;
            if (s1_rd) rsp_data <= dec_data;
            single_err       <= (s1_rd || in_check) && dec_single;
            double_err       <= (s1_rd || in_check) && dec_double;
            is_partial_write <= in_check && (dec_single || dec_double);
            if ((s1_rd || in_check) && (dec_single || dec_double)) begin
                err_index <= s1_addr;
                err_data  <= mem_rdata[DW-1:0];
            end
            if (in_check) begin
                merged_q <= merged;
                wr_ok_q  <= !dec_double;
            end
        end
    end

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |-> ##2 rsp_valid);

    // R6
    rmw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> !req_ready ##1 !req_ready);

    // R6
    rmw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RMW_CHECK) |-> !mem_en);

    // R5
    err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_err && double_err));

    // R7
    partial_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_partial_write |-> (single_err || double_err));

    // R8
    rmw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (double_err && is_partial_write) |-> !(mem_en && mem_we));

endmodule

// File: tb/test_secded_sram_ctrl.sv
module test_secded_sram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 64;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int PB    = 7;
    localparam int SW    = DW + PB + 1;
    localparam int NB    = DW / 8;
    localparam int NPOS  = DW + PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NB-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_wdata;
    logic [SW-1:0] mem_rdata;
    logic          single_err, double_err, is_partial_write;
    logic [AW-1:0] err_index;
    logic [DW-1:0] err_data;

    logic [SW-1:0] mem [DEPTH];
    logic [SW-1:0] rdq = '0;
    logic          bk_en = 1'b0;
    logic [AW-1:0] bk_addr = '0;
    logic [SW-1:0] bk_val = '0;
    logic [DW-1:0] golden [DEPTH];

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    secded_sram_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_secded_sram_ctrl (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
        .req_wdata, .rsp_valid, .rsp_data, .mem_en, .mem_we, .mem_addr,
        .mem_wdata, .mem_rdata, .single_err, .double_err, .is_partial_write,
        .err_index, .err_data
    );

    // SRAM model with back door for fault injection
    always @(posedge clk) begin
        if (bk_en) mem[bk_addr] <= bk_val;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        rdq <= mem[mem_addr];
        end
    end
    assign mem_rdata = rdq;

    function automatic logic [SW-1:0] ref_code(input logic [DW-1:0] d);
        logic [NPOS:0] cw;
        logic [PB-1:0] h;
        int n;
        cw = '0;
        n  = 0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[n];
                n++;
            end
        end
        for (int k = 0; k < PB; k++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p <= NPOS; p++) begin
                if (p[k] && ((p & (p - 1)) != 0)) x = x ^ cw[p];
            end
            h[k] = x;
        end
        return {h, ^{h, d}, d};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r;
        for (int j = 0; j < NB; j++) r[j*8 +: 8] = be[j] ? nw[j*8 +: 8] : old[j*8 +: 8];
        return r;
    endfunction

    task automatic chk(input logic [SW-1:0] act, input logic [SW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bk_write(input int a, input logic [SW-1:0] w);
        @(negedge clk);
        bk_en = 1'b1; bk_addr = AW'(a); bk_val = w;
        @(negedge clk);
        bk_en = 1'b0;
    endtask

    task automatic corrupt(input int nflip, input int b1_in, output logic [SW-1:0] bad,
                           input logic [SW-1:0] good, output int b1);
        int b2;
        bad = good;
        b1  = (b1_in >= 0) ? b1_in : int'($urandom % SW);
        if (nflip >= 1) bad[b1] = ~bad[b1];
        if (nflip == 2) begin
            b2 = (b1 + 1 + int'($urandom % (SW - 1))) % SW;
            bad[b2] = ~bad[b2];
        end
    endtask

    task automatic full_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a);
        req_be = '1; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        golden[a] = d;
        chk(mem[a], ref_code(d), "R1 stored word");
    endtask

    task automatic rd_check(input int a, input int nflip, input int pick);
        logic [SW-1:0] good, bad;
        int b1;
        string tag;
        good = ref_code(golden[a]);
        corrupt(nflip, pick, bad, good, b1);
        bk_write(a, bad);
        tag = (nflip == 0) ? "R2" : (nflip == 2) ? "R5" : (b1 < DW) ? "R3" : "R4";
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(SW'(rsp_valid), SW'(1), {tag, " rsp_valid"});
        chk(SW'(rsp_data), SW'((nflip == 2) ? bad[DW-1:0] : golden[a]), {tag, " rsp_data"});
        chk(SW'(single_err), SW'(nflip == 1), {tag, " single_err"});
        chk(SW'(double_err), SW'(nflip == 2), {tag, " double_err"});
        chk(SW'(is_partial_write), SW'(0), {tag, " partial flag"});
        if (nflip != 0) begin
            chk(SW'(err_index), SW'(a), {tag, " err_index"});
            chk(SW'(err_data), SW'(bad[DW-1:0]), {tag, " err_data"});
            chk(mem[a], bad, {tag, " stored word untouched"});
        end
        bk_write(a, good);
    endtask

    task automatic pw_check(input int a, input logic [NB-1:0] be_in,
                            input logic [DW-1:0] wd, input int nflip);
        logic [SW-1:0] good, bad;
        logic [NB-1:0] be;
        int b1;
        be = be_in;
        if (&be) be[0] = 1'b0;
        good = ref_code(golden[a]);
        corrupt(nflip, -1, bad, good, b1);
        bk_write(a, bad);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(SW'(req_ready), SW'(0), "R6 busy cycle 1");
        @(negedge clk);
        chk(SW'(req_ready), SW'(0), "R6 busy cycle 2");
        chk(SW'(single_err), SW'(nflip == 1), "R7 single_err");
        chk(SW'(double_err), SW'(nflip == 2), "R7 double_err");
        chk(SW'(is_partial_write), SW'(nflip != 0), "R7 is_partial_write");
        if (nflip != 0) chk(SW'(err_index), SW'(a), "R7 err_index");
        @(negedge clk);
        chk(SW'(req_ready), SW'(1), "R6 ready again");
        if (nflip == 2) begin
            chk(mem[a], bad, "R8 write suppressed");
            bk_write(a, good);
        end else begin
            golden[a] = merge(golden[a], wd, be);
            chk(mem[a], ref_code(golden[a]), "R6 merged word");
        end
    endtask

    task automatic b2b_reads(input int a1, input int a2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a1);
        @(negedge clk);
        chk(SW'(req_ready), SW'(1), "R10 ready between reads");
        req_addr = AW'(a2);
        @(negedge clk);
        req_valid = 1'b0;
        chk(SW'(rsp_valid), SW'(1), "R10 first valid");
        chk(SW'(rsp_data), SW'(golden[a1]), "R10 first data");
        @(negedge clk);
        chk(SW'(rsp_valid), SW'(1), "R10 second valid");
        chk(SW'(rsp_data), SW'(golden[a2]), "R10 second data");
        @(negedge clk);
        chk(SW'(rsp_valid), SW'(0), "R10 no extra response");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) golden[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) bk_write(i, ref_code(golden[i]));
        @(negedge clk);
        // R9 reset state
        chk(SW'(rsp_valid), SW'(0), "R9 rsp_valid");
        chk(SW'(single_err), SW'(0), "R9 single_err");
        chk(SW'(double_err), SW'(0), "R9 double_err");
        chk(SW'(is_partial_write), SW'(0), "R9 is_partial_write");
        chk(SW'(req_ready), SW'(1), "R9 req_ready");
        // directed corners
        full_write(0, 64'h0);
        full_write(1, '1);
        rd_check(0, 0, -1);
        rd_check(1, 1, 0);
        rd_check(1, 1, DW - 1);
        rd_check(0, 1, DW);
        rd_check(0, 1, SW - 1);
        rd_check(1, 2, 5);
        pw_check(2, 8'h0F, 64'hDEAD_BEEF_CAFE_F00D, 1);
        pw_check(3, 8'h01, 64'h1234_5678_9ABC_DEF0, 2);
        pw_check(4, 8'hF0, 64'h0F0F_0F0F_0F0F_0F0F, 0);
        b2b_reads(2, 4);
        // random mix
        for (int it = 0; it < 300; it++) begin
            int a, op;
            a  = int'($urandom % DEPTH);
            op = int'($urandom % 4);
            case (op)
                0: full_write(a, {$urandom, $urandom});
                1: rd_check(a, int'($urandom % 3), -1);
                2: pw_check(a, NB'($urandom), {$urandom, $urandom}, int'($urandom % 3));
                default: b2b_reads(a, int'($urandom % DEPTH));
            endcase
        end
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule